// File: doc/BRIEF.md
# Two-Step Converter Control Sequencer

This block is the digital control and output logic of an 8-bit converter that resolves its result in two steps. An upper comparator bank first finds the top nibble and a lower bank then resolves the residue to give the bottom nibble. The comparator banks are outside the block. They arrive as two 15-bit thermometer codes plus one overrange bit. The block sets the zero or compare phase of each bank. It sequences a conversion, encodes and latches both halves, and presents the result on a data bus that has a separate enable. It also drives an active-low interrupt, an open-drain ready request and an overflow flag that is always driven.

A strap input picks one of two host interfaces. With the strap low, a single read strobe both starts the conversion and collects its result, and both steps are timed internally. With the strap high, a write strobe starts the conversion and a later read collects the result. The result is stored by an internal timeout, or earlier if the read arrives first. All strobes are active low, are synchronous to the block clock, and are taken only while chip select is low. All delays are parameters counted in clock cycles.

Top module: `hf_adc_seq`

## Requirements
- R1: With the strap low, a conversion starts at the clock edge that first samples read low while select is low. With the strap high, it starts at the edge that first samples write low while select is low. A falling read in write mode, or any strobe while select is high, starts nothing.
- R2: In read mode the upper nibble is taken STEP_CYC edges after the start edge, and the result is stored STEP_CYC edges after that. The interrupt falls at the 2*STEP_CYC-th edge after the start edge.
- R3: The phase outputs are 1 for compare and 0 for zero. The first cycle of a conversion has the upper bank comparing and the lower bank zeroing. The banks then swap, and both are never comparing at once. Outside a conversion both banks are zeroing.
- R4: In write mode the upper bank compares while write stays low. The edge that samples write high takes the upper nibble and puts the lower bank into compare. Without an early read, the result is stored TOUT_CYC edges after that edge.
- R5: In write mode, while the lower bank compares, a read falling with select low stores the result at that edge. The interrupt falls and the bus shows the result in the same cycle.
- R6: The interrupt is set high one cycle after read or select is sampled rising, unless a store happens at that edge.
- R7: In read mode, the ready request (1 = line pulled low) sets one cycle after select is sampled falling. It clears when the result is stored or when select rises. It never sets in write mode.
- R8: The data enable is 1 only one cycle after select and read were both sampled low. In read mode it stays 0 until the result is stored.
- R9: Each 15-bit code is encoded as the number of ones it holds, so a code that is not a clean thermometer is still counted. The data bus is {upper nibble, lower nibble}, with the upper nibble in bits 7:4.
- R10: The overflow output is low when the overrange bit was 1 at the moment the upper nibble was taken. It changes only when a result is stored and has no enable.
- R11: For REC_CYC edges after a store, both banks zero and any start strobe is ignored, including one sampled at the REC_CYC-th edge.
- R12: In reset the interrupt is high, ready is released, the data enable is 0, overflow is high and both banks are zeroing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr_i | input | 1 | Strap: 0 read mode, 1 write-then-read mode |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| hi_therm_i | input | TW | Upper bank thermometer code |
| ovr_cmp_i | input | 1 | Overrange comparator of the upper bank |
| lo_therm_i | input | TW | Lower bank thermometer code |
| hi_cmp_o | output | 1 | Upper bank phase: 1 compare, 0 zero |
| lo_cmp_o | output | 1 | Lower bank phase: 1 compare, 0 zero |
| data_o | output | DW | Latched conversion result |
| data_oe_o | output | 1 | Drive enable for the data bus |
| irq_n_o | output | 1 | Conversion-done interrupt, active low |
| rdy_pull_o | output | 1 | 1 pulls the open-drain ready line low |
| ovf_n_o | output | 1 | Overflow flag, active low, always driven |

## Verification
The assertions rely on a few things about the inputs. The strap is held fixed while select is low. A read does not rise in the same cycle as a store in the lower-compare step. The strobes are already synchronous to the clock. The stimulus respects these rules: it changes the strap only when select is high and the block is idle. It drives all strobes at the falling clock edge. It keeps the thermometer codes steady from the start of a conversion until its result is stored, and it waits out the recovery time between conversions, except in the one test that targets it.

// File: rtl/hf_pkg.sv
package hf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD_HI = 3'd1,
        ST_RD_LO = 3'd2,
        ST_WR_HI = 3'd3,
        ST_WR_LO = 3'd4,
        ST_RECOV = 3'd5
    } hf_state_e;

    localparam int STB_CS = 0;
    localparam int STB_RD = 1;
    localparam int STB_WR = 2;
    localparam int STB_N  = 3;

endpackage

// File: rtl/hf_therm_enc.sv
module hf_therm_enc #(
    parameter int NB = 4,
    localparam int TW = (1 << NB) - 1
) (
    input  logic [TW-1:0] therm_i,
    output logic [NB-1:0] code_o
);
    // population count: tolerant of bubbles in the code
    always_comb begin
        code_o = '0;
        for (int i = 0; i < TW; i++) begin
            code_o = code_o + {{(NB-1){1'b0}}, therm_i[i]};
        end
    end
endmodule

// File: rtl/hf_edge_det.sv
module hf_edge_det #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] fall_o,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        fall_o = prev_q & ~lvl_i;
        rise_o = ~prev_q & lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/hf_seq.sv
module hf_seq
    import hf_pkg::*;
#(
    parameter int NB       = 4,
    parameter int STEP_CYC = 200,
    parameter int TOUT_CYC = 200,
    parameter int REC_CYC  = 125
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_i,
    input  logic          cs_n_i,
    input  logic          rd_fall_i,
    input  logic          wr_fall_i,
    input  logic          wr_rise_i,
    input  logic [NB-1:0] hi_code_i,
    input  logic          ovr_i,
    output logic          hi_cmp_o,
    output logic          lo_cmp_o,
    output logic [NB-1:0] hi_nib_o,
    output logic          ovr_o,
    output logic          strobe_o,
    output logic          rd_busy_o
);
    localparam int MAX_AB = (STEP_CYC > TOUT_CYC) ? STEP_CYC : TOUT_CYC;
    localparam int MAXC   = (MAX_AB > REC_CYC) ? MAX_AB : REC_CYC;
    localparam int CW     = $clog2(MAXC + 1);
    localparam logic [CW-1:0] STEP_LAST = CW'(STEP_CYC - 1);
    localparam logic [CW-1:0] TOUT_LAST = CW'(TOUT_CYC - 1);
    localparam logic [CW-1:0] REC_LAST  = CW'(REC_CYC - 1);

    typedef struct packed {
        hf_state_e     st;
        logic [CW-1:0] cnt;
        logic [NB-1:0] hi_nib;
        logic          ovr;
        logic          hi_cmp;
        logic          lo_cmp;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        strobe_o = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                s_d.cnt = '0;
                if (!cs_n_i && rd_fall_i && !mode_i)     s_d.st = ST_RD_HI;
                else if (!cs_n_i && wr_fall_i && mode_i) s_d.st = ST_WR_HI;
            end
            ST_RD_HI: begin
                if (s_q.cnt == STEP_LAST) begin
                    s_d.st     = ST_RD_LO;
                    s_d.cnt    = '0;
                    s_d.hi_nib = hi_code_i;
                    s_d.ovr    = ovr_i;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_RD_LO: begin
                if (s_q.cnt == STEP_LAST) begin
                    strobe_o = 1'b1;
                    s_d.st   = ST_RECOV;
                    s_d.cnt  = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_WR_HI: begin
                if (wr_rise_i) begin
                    s_d.st     = ST_WR_LO;
                    s_d.cnt    = '0;
                    s_d.hi_nib = hi_code_i;
                    s_d.ovr    = ovr_i;
                end
            end
            ST_WR_LO: begin
                if ((!cs_n_i && rd_fall_i) || (s_q.cnt == TOUT_LAST)) begin
                    strobe_o = 1'b1;
                    s_d.st   = ST_RECOV;
                    s_d.cnt  = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_RECOV: begin
                if (s_q.cnt == REC_LAST) begin
                    s_d.st  = ST_IDLE;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: begin
                s_d.st  = ST_IDLE;
                s_d.cnt = '0;
            end
        endcase
        s_d.hi_cmp = (s_d.st == ST_RD_HI) || (s_d.st == ST_WR_HI);
        s_d.lo_cmp = (s_d.st == ST_RD_LO) || (s_d.st == ST_WR_LO);
        rd_busy_o  = (s_d.st == ST_RD_HI) || (s_d.st == ST_RD_LO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, cnt: '0, hi_nib: '0, ovr: 1'b0,
                             hi_cmp: 1'b0, lo_cmp: 1'b0};
        else        s_q <= s_d;
    end

    assign hi_cmp_o = s_q.hi_cmp;
    assign lo_cmp_o = s_q.lo_cmp;
    assign hi_nib_o = s_q.hi_nib;
    assign ovr_o    = s_q.ovr;
endmodule

// File: rtl/hf_outlatch.sv
module hf_outlatch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_i,
    input  logic          cs_n_i,
    input  logic          rd_n_i,
    input  logic          cs_fall_i,
    input  logic          cs_rise_i,
    input  logic          rd_rise_i,
    input  logic          strobe_i,
    input  logic          rd_busy_i,
    input  logic [DW-1:0] result_i,
    input  logic          ovr_i,
    output logic [DW-1:0] data_o,
    output logic          data_oe_o,
    output logic          irq_n_o,
    output logic          rdy_pull_o,
    output logic          ovf_n_o
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          ovf_n;
        logic          irq_n;
        logic          rdy;
        logic          oe;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        // interrupt: store wins over a clearing edge
        if (strobe_i)                    o_d.irq_n = 1'b0;
        else if (rd_rise_i || cs_rise_i) o_d.irq_n = 1'b1;
        // ready request: release wins over set
        if (strobe_i || cs_rise_i)       o_d.rdy = 1'b0;
        else if (cs_fall_i && !mode_i)   o_d.rdy = 1'b1;
        if (strobe_i) begin
            o_d.data  = result_i;
            o_d.ovf_n = ~ovr_i;
        end
        o_d.oe = !cs_n_i && !rd_n_i && !rd_busy_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '{data: '0, ovf_n: 1'b1, irq_n: 1'b1, rdy: 1'b0, oe: 1'b0};
        else        o_q <= o_d;
    end

    assign data_o     = o_q.data;
    assign data_oe_o  = o_q.oe;
    assign irq_n_o    = o_q.irq_n;
    assign rdy_pull_o = o_q.rdy;
    assign ovf_n_o    = o_q.ovf_n;
endmodule

// File: rtl/hf_adc_seq.sv
module hf_adc_seq
    import hf_pkg::*;
#(
    parameter int NB       = 4,
    parameter int STEP_CYC = 200,
    parameter int TOUT_CYC = 200,
    parameter int REC_CYC  = 125,
    localparam int TW = (1 << NB) - 1,
    localparam int DW = 2 * NB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr_i,
    input  logic          cs_n_i,
    input  logic          rd_n_i,
    input  logic          wr_n_i,
    input  logic [TW-1:0] hi_therm_i,
    input  logic          ovr_cmp_i,
    input  logic [TW-1:0] lo_therm_i,
    output logic          hi_cmp_o,
    output logic          lo_cmp_o,
    output logic [DW-1:0] data_o,
    output logic          data_oe_o,
    output logic          irq_n_o,
    output logic          rdy_pull_o,
    output logic          ovf_n_o
);
    logic [STB_N-1:0] lvl, fall, rise;
    logic [TW-1:0]    therm [2];
    logic [NB-1:0]    code  [2];
    logic [NB-1:0]    hi_nib;
    logic             ovr_held, strobe, rd_busy;

    assign lvl[STB_CS] = cs_n_i;
    assign lvl[STB_RD] = rd_n_i;
    assign lvl[STB_WR] = wr_n_i;
    assign therm[0]    = lo_therm_i;
    assign therm[1]    = hi_therm_i;

    hf_edge_det #(.N(STB_N)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .fall_o(fall), .rise_o(rise)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        hf_therm_enc #(.NB(NB)) u_enc (.therm_i(therm[b]), .code_o(code[b]));
    end

    hf_seq #(.NB(NB), .STEP_CYC(STEP_CYC), .TOUT_CYC(TOUT_CYC), .REC_CYC(REC_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_wr_i), .cs_n_i(cs_n_i),
        .rd_fall_i(fall[STB_RD]), .wr_fall_i(fall[STB_WR]), .wr_rise_i(rise[STB_WR]),
        .hi_code_i(code[1]), .ovr_i(ovr_cmp_i),
        .hi_cmp_o(hi_cmp_o), .lo_cmp_o(lo_cmp_o), .hi_nib_o(hi_nib), .ovr_o(ovr_held),
        .strobe_o(strobe), .rd_busy_o(rd_busy)
    );

    hf_outlatch #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_wr_i), .cs_n_i(cs_n_i), .rd_n_i(rd_n_i),
        .cs_fall_i(fall[STB_CS]), .cs_rise_i(rise[STB_CS]), .rd_rise_i(rise[STB_RD]),
        .strobe_i(strobe), .rd_busy_i(rd_busy), .result_i({hi_nib, code[0]}),
        .ovr_i(ovr_held), .data_o(data_o), .data_oe_o(data_oe_o), .irq_n_o(irq_n_o),
        .rdy_pull_o(rdy_pull_o), .ovf_n_o(ovf_n_o)
    );
endmodule

// File: rtl/hf_adc_seq_chk.sv
module hf_adc_seq_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_wr_i,
    input logic          cs_n_i,
    input logic          rd_n_i,
    input logic          hi_cmp_o,
    input logic          lo_cmp_o,
    input logic [DW-1:0] data_o,
    input logic          data_oe_o,
    input logic          irq_n_o,
    input logic          rdy_pull_o,
    input logic          ovf_n_o
);
    AST_BANKS_NOT_BOTH_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_cmp_o && lo_cmp_o)); // R3
    AST_LO_FOLLOWS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_cmp_o) |-> $past(hi_cmp_o)); // R3
    AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> $past(!cs_n_i && !rd_n_i)); // R8
    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (($rose(rd_n_i) || $rose(cs_n_i)) && !lo_cmp_o) |=> irq_n_o); // R6
    AST_OVF_AT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ovf_n_o) |-> !irq_n_o); // R10
    AST_DATA_AT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_o) |-> !irq_n_o); // R9
    AST_RDY_READ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_pull_o |-> !mode_wr_i); // R7
endmodule

bind hf_adc_seq hf_adc_seq_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_wr_i(mode_wr_i), .cs_n_i(cs_n_i), .rd_n_i(rd_n_i),
    .hi_cmp_o(hi_cmp_o), .lo_cmp_o(lo_cmp_o), .data_o(data_o), .data_oe_o(data_oe_o),
    .irq_n_o(irq_n_o), .rdy_pull_o(rdy_pull_o), .ovf_n_o(ovf_n_o)
);

// File: tb/tb_hf_adc_seq.sv
module tb_hf_adc_seq;
    localparam int STEP = 6;
    localparam int TOUT = 10;
    localparam int REC  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ovr = 1'b0;
    logic [14:0] hi = '0, lo = '0;
    logic hi_cmp, lo_cmp, oe, irq_n, rdy, ovf_n;
    logic [7:0] data;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    hf_adc_seq #(.NB(4), .STEP_CYC(STEP), .TOUT_CYC(TOUT), .REC_CYC(REC)) dut (
        .clk(clk), .rst_n(rst_n), .mode_wr_i(mode), .cs_n_i(cs_n), .rd_n_i(rd_n),
        .wr_n_i(wr_n), .hi_therm_i(hi), .ovr_cmp_i(ovr), .lo_therm_i(lo),
        .hi_cmp_o(hi_cmp), .lo_cmp_o(lo_cmp), .data_o(data), .data_oe_o(oe),
        .irq_n_o(irq_n), .rdy_pull_o(rdy), .ovf_n_o(ovf_n)
    );

    typedef struct packed {
        logic        mode;
        logic [14:0] hi;
        logic        ovr;
        logic [14:0] lo;
        logic        early;
        logic [7:0]  data;
        logic        ovf_n;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 15'h0000, 1'b0, 15'h0000, 1'b0, 8'h00, 1'b1},
        '{1'b0, 15'h7FFF, 1'b1, 15'h7FFF, 1'b0, 8'hFF, 1'b0},
        '{1'b0, 15'h00FF, 1'b0, 15'h0007, 1'b0, 8'h83, 1'b1},
        '{1'b1, 15'h001F, 1'b0, 15'h03FF, 1'b0, 8'h5A, 1'b1},
        '{1'b1, 15'h0055, 1'b0, 15'h1248, 1'b1, 8'h44, 1'b1},
        '{1'b1, 15'h0001, 1'b1, 15'h7FFE, 1'b1, 8'h1E, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic conv_rd(input vec_t v);
        int n = 0;
        @(negedge clk);
        mode = 1'b0; hi = v.hi; ovr = v.ovr; lo = v.lo; cs_n = 1'b0;
        @(negedge clk);
        chk(rdy == 1'b1, "R7 ready on select", rdy, 1);
        rd_n = 1'b0;
        while (n < 200) begin
            @(posedge clk); #1; n++;
            if (n == 1)        chk(hi_cmp && !lo_cmp, "R3 first step", {hi_cmp, lo_cmp}, 2);
            if (n == 2)        chk(!oe, "R8 bus off while converting", oe, 0);
            if (n == STEP + 1) chk(!hi_cmp && lo_cmp, "R3 swap", {hi_cmp, lo_cmp}, 1);
            if (!irq_n) break;
        end
        chk(n == 2 * STEP + 1, "R2 conversion length", n, 2 * STEP + 1);
        chk(data == v.data, "R9 result", data, v.data);
        chk(ovf_n == v.ovf_n, "R10 overflow", ovf_n, v.ovf_n);
        chk(oe, "R8 bus on at end", oe, 1);
        chk(!rdy, "R7 ready released", rdy, 0);
        @(negedge clk); rd_n = 1'b1;
        @(posedge clk); #1;
        chk(irq_n, "R6 read rise clears", irq_n, 1);
        chk(!oe, "R8 bus off after read", oe, 0);
        @(negedge clk); cs_n = 1'b1;
        repeat (REC + 2) @(negedge clk);
    endtask

    task automatic conv_wr(input vec_t v);
        int n = 0;
        @(negedge clk);
        mode = 1'b1; hi = v.hi; ovr = v.ovr; lo = v.lo; cs_n = 1'b0; rd_n = 1'b1;
        @(negedge clk); wr_n = 1'b0;
        @(posedge clk); #1;
        chk(hi_cmp && !lo_cmp, "R4 upper compares", {hi_cmp, lo_cmp}, 2);
        chk(!rdy, "R7 no ready in write mode", rdy, 0);
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        @(posedge clk); #1; n = 1;
        chk(!hi_cmp && lo_cmp, "R4 lower compares", {hi_cmp, lo_cmp}, 1);
        if (v.early) begin
            @(negedge clk); rd_n = 1'b0;
            @(posedge clk); #1;
            chk(!irq_n, "R5 early read interrupt", irq_n, 0);
            chk(oe && data == v.data, "R5 early read data", {oe, data}, {1'b1, v.data});
            chk(ovf_n == v.ovf_n, "R10 overflow", ovf_n, v.ovf_n);
            @(negedge clk); rd_n = 1'b1;
            @(posedge clk); #1;
            chk(irq_n, "R6 read rise clears", irq_n, 1);
        end else begin
            while (n < 200 && irq_n) begin
                @(posedge clk); #1; n++;
            end
            chk(n == TOUT + 1, "R4 timeout store", n, TOUT + 1);
            chk(data == v.data, "R9 result", data, v.data);
            chk(ovf_n == v.ovf_n, "R10 overflow", ovf_n, v.ovf_n);
            chk(!oe, "R8 no bus without read", oe, 0);
            @(negedge clk); cs_n = 1'b1;
            @(posedge clk); #1;
            chk(irq_n, "R6 select rise clears", irq_n, 1);
        end
        @(negedge clk); cs_n = 1'b1;
        repeat (REC + 2) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(irq_n && !rdy && !oe && ovf_n && !hi_cmp && !lo_cmp, "R12 reset state",
            {irq_n, rdy, oe, ovf_n, hi_cmp, lo_cmp}, 6'b100100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].mode) conv_wr(VECS[i]);
            else              conv_rd(VECS[i]);
        end

        // R1 read strobe in write mode starts nothing
        @(negedge clk); mode = 1'b1; cs_n = 1'b0;
        @(negedge clk); rd_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!hi_cmp && irq_n, "R1 read ignored in write mode", {hi_cmp, irq_n}, 1);
        rd_n = 1'b1; cs_n = 1'b1;
        // R1 read with select high starts nothing
        @(negedge clk); mode = 1'b0;
        @(negedge clk); rd_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!hi_cmp && !rdy, "R1 unselected read ignored", {hi_cmp, rdy}, 0);
        rd_n = 1'b1;

        // R11 start inside recovery window is ignored
        @(negedge clk); mode = 1'b1; cs_n = 1'b0; hi = 15'h0003; lo = 15'h0001; ovr = 1'b0;
        @(negedge clk); wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        while (irq_n) begin
            @(posedge clk); #1;
        end
        repeat (REC) @(negedge clk);
        wr_n = 1'b0;
        @(posedge clk); #1;
        chk(!hi_cmp && !lo_cmp, "R11 start at last recovery edge", {hi_cmp, lo_cmp}, 0);
        repeat (2) @(posedge clk); #1;
        chk(!hi_cmp, "R11 still idle", hi_cmp, 0);
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); wr_n = 1'b0;
        @(posedge clk); #1;
        chk(hi_cmp, "R11 start after recovery", hi_cmp, 1);
        @(negedge clk); wr_n = 1'b1;
        repeat (TOUT + REC + 4) @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule